// File: doc/BRIEF.md
# Stride Reference Prediction Table

This block watches the stream of memory instructions leaving a core and learns, separately for each instruction, whether it walks through memory with a fixed step. Each instruction is identified by its program counter. The low PC bits above the instruction alignment select one slot of a direct-mapped table, and the remaining high bits are stored as an owner tag. A slot remembers the last effective address its instruction touched, the step between its last two addresses, and a confidence state.

Every valid request reads its slot, compares the new step with the stored one, rewrites the slot and, once the step has been confirmed, produces a prefetch candidate equal to the current address plus the step. A candidate is never produced for a step of zero. Steps are two's-complement, so descending walks are learned too. The candidate appears two clock edges after the request and is held for one cycle. Sending it to the memory system is left to the logic downstream.

Top module: `stride_rpt`

## Requirements
- R1: After reset every slot is empty. The first access of any PC after reset yields no prefetch, even if that PC had reached the confirmed state before the reset.
- R2: A request sampled at clock edge k drives its result onto `pf_valid`/`pf_addr` after edge k+1. `pf_valid` is high for exactly one cycle per qualifying request and is low otherwise.
- R3: A request whose slot is empty or owned by another tag allocates the slot. The slot takes the request's tag and address, a step of 0 and the initial state, and no prefetch is produced.
- R4: When a slot in the initial state sees a step different from the stored one, it stores the new step, moves to the transient state and produces no prefetch.
- R5: A matching step in the transient state moves the slot to the confirmed state and produces a prefetch at address + step.
- R6: While the steps keep matching, a confirmed slot produces a prefetch on every access.
- R7: A repeating step of 0 confirms the slot directly from the initial state, but no prefetch is produced while the step is 0.
- R8: A step mismatch in the confirmed state stores the new step and returns the slot to the initial state with no prefetch. One further matching step confirms it again and produces a prefetch.
- R9: A step mismatch in the transient state stores the new step and moves the slot to a no-prediction state. Only two consecutive matching steps after that produce a prefetch, on the second of them.
- R10: A PC that maps to an occupied slot with a different tag replaces the slot. The previous owner then finds the slot gone and must learn its pattern again from the start.
- R11: Steps are signed: a descending sequence produces prefetch addresses below the current address.
- R12: Requests to the same PC on consecutive cycles give the same results as the same requests with idle cycles between them.
- R13: PCs that map to different slots are tracked independently when interleaved.
- R14: A cycle with `req_valid` low changes no slot and produces no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A memory instruction is presented this cycle |
| req_pc | input | PC_W | Program counter of the memory instruction |
| req_addr | input | ADDR_W | Effective address of the access |
| pf_valid | output | 1 | Registered prefetch candidate strobe |
| pf_addr | output | ADDR_W | Registered prefetch candidate address |

## Verification
A corrupted slot (wrong stored step, stale previous address, wrong state or tag) has no effect on the ports until its PC is used again. On that access it shows up as a missing, extra or misaddressed prefetch two edges later. A state fault can stay hidden for up to two further accesses of the same PC, because only the confirmed state produces output. The stimulus therefore drives each state transition and then follows it with enough accesses to the same PC to bring the resulting state out at `pf_valid`. The back-to-back sequence covers the case where a slot's write-back and its next read fall on the same edge.

// File: rtl/stride_rpt_pkg.sv
package stride_rpt_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } rpt_state_e;

endpackage

// File: rtl/rpt_store.sv
module rpt_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  // Payload array: no reset, synchronous read, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  // Occupancy bits live in flops so that reset can clear them at once.
  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)                                    vld[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g)))    vld[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= vld[rd_idx];
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0 && !rd_vld));

endmodule

// File: rtl/rpt_update.sv
module rpt_update
  import stride_rpt_pkg::*;
#(
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32
) (
  input  logic              cur_vld,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [ADDR_W-1:0] cur_prev,
  input  logic [ADDR_W-1:0] cur_stride,
  input  rpt_state_e        cur_state,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [TAG_W-1:0]  nxt_tag,
  output logic [ADDR_W-1:0] nxt_prev,
  output logic [ADDR_W-1:0] nxt_stride,
  output rpt_state_e        nxt_state,
  output logic              pf_fire,
  output logic [ADDR_W-1:0] pf_target
);

  logic [ADDR_W-1:0] seen_stride;
  logic              same_stride;

  assign hit         = cur_vld && (cur_tag == req_tag);
  assign seen_stride = req_addr - cur_prev;   // two's-complement step
  assign same_stride = (seen_stride == cur_stride);

  always_comb begin
    nxt_tag    = req_tag;
    nxt_prev   = req_addr;                    // always tracks the last address
    nxt_stride = cur_stride;
    nxt_state  = cur_state;
    if (!hit) begin
      nxt_stride = '0;
      nxt_state  = ST_INIT;
    end else begin
      unique case (cur_state)
        ST_INIT: begin
          if (same_stride) nxt_state = ST_STEADY;
          else begin
            nxt_state  = ST_TRANS;
            nxt_stride = seen_stride;
          end
        end
        ST_TRANS: begin
          if (same_stride) nxt_state = ST_STEADY;
          else begin
            nxt_state  = ST_NOPRED;
            nxt_stride = seen_stride;
          end
        end
        ST_STEADY: begin
          if (!same_stride) begin
            nxt_state  = ST_INIT;
            nxt_stride = seen_stride;
          end
        end
        ST_NOPRED: begin
          if (same_stride) nxt_state = ST_TRANS;
          else             nxt_stride = seen_stride;
        end
        default: nxt_state = ST_INIT;
      endcase
    end
  end

  assign pf_fire   = hit && (nxt_state == ST_STEADY) && (nxt_stride != '0);
  assign pf_target = req_addr + nxt_stride;

endmodule

// File: rtl/stride_rpt.sv
module stride_rpt
  import stride_rpt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TAG_W = PC_W - IDX_W - PC_LSB;
  localparam int ENT_W = TAG_W + 2 * ADDR_W + ST_W;

  // ---------------- stage 0: index and read ----------------
  logic [IDX_W-1:0]  in_idx;
  logic [TAG_W-1:0]  in_tag;
  assign in_idx = req_pc[PC_LSB +: IDX_W];
  assign in_tag = req_pc[PC_W-1 -: TAG_W];

  logic              s1_valid;
  logic [IDX_W-1:0]  s1_idx;
  logic [TAG_W-1:0]  s1_tag;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
    s1_idx  <= in_idx;
    s1_tag  <= in_tag;
    s1_addr <= req_addr;
  end

  logic [ENT_W-1:0] rd_word;
  logic             rd_vld;
  logic [ENT_W-1:0] nxt_word;

  rpt_store #(.DEPTH(DEPTH), .DATA_W(ENT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (in_idx),
    .rd_data (rd_word),
    .rd_vld  (rd_vld),
    .wr_en   (s1_valid),
    .wr_idx  (s1_idx),
    .wr_data (nxt_word)
  );

  // The slot written at an edge may be the one read at that same edge:
  // capture the written value and use it instead of the stale RAM data.
  logic             fwd_q;
  logic [ENT_W-1:0] fwd_word;

  always_ff @(posedge clk) begin
    if (rst) fwd_q <= 1'b0;
    else     fwd_q <= s1_valid && (s1_idx == in_idx);
    fwd_word <= nxt_word;
  end

  // ---------------- stage 1: update ----------------
  logic [ENT_W-1:0]  cur_word;
  logic              cur_vld;
  logic [TAG_W-1:0]  cur_tag;
  logic [ADDR_W-1:0] cur_prev;
  logic [ADDR_W-1:0] cur_stride;
  rpt_state_e        cur_state;

  assign cur_word   = fwd_q ? fwd_word : rd_word;
  assign cur_vld    = fwd_q | rd_vld;
  assign cur_tag    = cur_word[ENT_W-1 -: TAG_W];
  assign cur_prev   = cur_word[ST_W + ADDR_W +: ADDR_W];
  assign cur_stride = cur_word[ST_W +: ADDR_W];
  assign cur_state  = rpt_state_e'(cur_word[ST_W-1:0]);

  logic              upd_hit;
  logic [TAG_W-1:0]  nxt_tag;
  logic [ADDR_W-1:0] nxt_prev;
  logic [ADDR_W-1:0] nxt_stride;
  rpt_state_e        nxt_state;
  logic              pf_fire;
  logic [ADDR_W-1:0] pf_target;

  rpt_update #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_update (
    .cur_vld    (cur_vld),
    .cur_tag    (cur_tag),
    .cur_prev   (cur_prev),
    .cur_stride (cur_stride),
    .cur_state  (cur_state),
    .req_tag    (s1_tag),
    .req_addr   (s1_addr),
    .hit        (upd_hit),
    .nxt_tag    (nxt_tag),
    .nxt_prev   (nxt_prev),
    .nxt_stride (nxt_stride),
    .nxt_state  (nxt_state),
    .pf_fire    (pf_fire),
    .pf_target  (pf_target)
  );

  assign nxt_word = {nxt_tag, nxt_prev, nxt_stride, nxt_state};

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= s1_valid && pf_fire;
      if (s1_valid && pf_fire) pf_addr <= pf_target;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> $past(req_valid, 2));

  assert_step_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr != $past(req_addr, 2)));

  assert_alloc_init_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !upd_hit) |-> (nxt_state == ST_INIT && nxt_stride == '0 && !pf_fire));

  assert_steady_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && upd_hit && cur_state == ST_STEADY && (s1_addr - cur_prev) == cur_stride)
      |-> (nxt_state == ST_STEADY));

  assert_nopred_slow_R9: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && upd_hit && cur_state == ST_NOPRED) |-> (nxt_state != ST_STEADY && !pf_fire));

endmodule

// File: tb/stride_rpt_bench.sv
`timescale 1ns/1ps
module stride_rpt_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_pc;
  logic [31:0] req_addr;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  stride_rpt u_stride_rpt (
    .clk (clk), .rst (rst), .req_valid (req_valid),
    .req_pc (req_pc), .req_addr (req_addr),
    .pf_valid (pf_valid), .pf_addr (pf_addr)
  );

  // PCs: slot = pc[5:2]; PC_E shares slot 0 with PC_A under another tag.
  localparam logic [31:0] PC_A = 32'h0000_1000;
  localparam logic [31:0] PC_B = 32'h0000_1004;
  localparam logic [31:0] PC_C = 32'h0000_1008;
  localparam logic [31:0] PC_D = 32'h0000_100C;
  localparam logic [31:0] PC_E = 32'h0000_2000;
  localparam logic [31:0] PC_F = 32'h0000_1010;

  // {pc, addr, expected pf_valid, expected pf_addr}
  localparam int NV = 22;
  localparam logic [96:0] VEC [NV] = '{
    {PC_A, 32'h0000_8000, 1'b0, 32'h0},          // R3 allocate
    {PC_A, 32'h0000_8010, 1'b0, 32'h0},          // R4 transient
    {PC_A, 32'h0000_8020, 1'b1, 32'h0000_8030},  // R5 confirm
    {PC_A, 32'h0000_8030, 1'b1, 32'h0000_8040},  // R6 keep going
    {PC_B, 32'h0000_9000, 1'b0, 32'h0},          // R13 other slot
    {PC_A, 32'h0000_8040, 1'b1, 32'h0000_8050},  // R13 A undisturbed
    {PC_B, 32'h0000_9000, 1'b0, 32'h0},          // R7 zero step confirms
    {PC_B, 32'h0000_9000, 1'b0, 32'h0},          // R7 still silent
    {PC_B, 32'h0000_9004, 1'b0, 32'h0},          // R8 mismatch -> initial
    {PC_B, 32'h0000_9008, 1'b1, 32'h0000_900C},  // R8 reconfirmed
    {PC_C, 32'h0000_4000, 1'b0, 32'h0},          // R9 allocate
    {PC_C, 32'h0000_4008, 1'b0, 32'h0},          // R9 transient +8
    {PC_C, 32'h0000_4000, 1'b0, 32'h0},          // R9 mismatch -> no-prediction
    {PC_C, 32'h0000_3FF8, 1'b0, 32'h0},          // R9 first match, silent
    {PC_C, 32'h0000_3FF0, 1'b1, 32'h0000_3FE8},  // R9 R11 second match
    {PC_D, 32'h0000_7000, 1'b0, 32'h0},          // R11 allocate
    {PC_D, 32'h0000_6FC0, 1'b0, 32'h0},          // R11 step -64
    {PC_D, 32'h0000_6F80, 1'b1, 32'h0000_6F40},  // R11 descending prefetch
    {PC_E, 32'h0000_5000, 1'b0, 32'h0},          // R10 evicts A
    {PC_A, 32'h0000_8050, 1'b0, 32'h0},          // R10 A misses
    {PC_A, 32'h0000_8060, 1'b0, 32'h0},          // R10 relearning
    {PC_A, 32'h0000_8070, 1'b1, 32'h0000_8080}   // R10 confirmed again
  };

  task automatic check(input string req, input logic expv, input logic [31:0] expa);
    n_checks++;
    if (pf_valid !== expv || (expv && pf_addr !== expa)) begin
      n_fail++;
      $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
               req, pf_valid, pf_addr, expv, expa);
    end
  endtask

  // One isolated request; result sampled after the second edge.
  task automatic one_req(input logic [31:0] pc, input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_pc = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset output", 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      one_req(VEC[i][96:65], VEC[i][64:33]);
      check($sformatf("table[%0d]", i), VEC[i][32], VEC[i][31:0]);
    end

    // R2: the strobe of the last vector lasts one cycle
    @(negedge clk);
    check("R2 single-cycle pulse", 1'b0, 32'h0);

    // R14: idle cycles with garbage on the bus leave D's slot untouched
    req_valid = 1'b0; req_pc = PC_D; req_addr = 32'h1234_5678;
    @(negedge clk);
    check("R14 idle no output", 1'b0, 32'h0);
    @(negedge clk);
    check("R14 idle no output 2", 1'b0, 32'h0);
    one_req(PC_D, 32'h0000_6F40);
    check("R14 slot unchanged", 1'b1, 32'h0000_6F00);

    // R12: back-to-back requests to one PC (slot 4)
    @(negedge clk);
    req_valid = 1'b1; req_pc = PC_F; req_addr = 32'h0000_0100;
    @(negedge clk);
    req_addr = 32'h0000_0108;
    @(negedge clk);
    check("R12 b2b first", 1'b0, 32'h0);
    req_addr = 32'h0000_0110;
    @(negedge clk);
    check("R12 b2b second", 1'b0, 32'h0);
    req_addr = 32'h0000_0118;
    @(negedge clk);
    check("R12 b2b third", 1'b1, 32'h0000_0118);
    req_valid = 1'b0;
    @(negedge clk);
    check("R12 b2b fourth", 1'b1, 32'h0000_0120);
    @(negedge clk);
    check("R2 b2b pulse ends", 1'b0, 32'h0);

    // R1: reset forgets the confirmed slot of D
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 output after reset", 1'b0, 32'h0);
    one_req(PC_D, 32'h0000_6F00);
    check("R1 slot empty after reset", 1'b0, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule